// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

After reset this block issues the fixed series of commands that brings an external DDR1 or DDR2 memory into a usable state. The commands are precharge-all, the mode register loads, the extended mode register loads and auto refreshes. A strap input chooses which of the two series runs. The block samples the strap once, on the first clock edge after reset is released.

Each command is offered on a valid/ready handshake. A command comes with a one-hot command code and the register value the memory needs. Once a command has been accepted, the block waits a fixed number of clock cycles before it offers the next one. After the wait that follows the last command, the block drives the refresh control word with its enable bit set. One cycle later it raises a done flag, and the flag stays high until the next reset.

A DRAM controller uses the block at power-up. The controller forwards each accepted command to the memory. It then hands the refresh control word to its own refresh engine.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted, `cmd_valid` is 0, `refresh_word` is 0 and `init_done` is 0.
- R2: Whenever `cmd_valid` is high, exactly one bit of `cmd_code` is set. The bits mean: bit 0 load mode register, bit 1 load extended mode register, bit 2 auto refresh, bit 3 precharge all, bit 4 load second extended register, bit 5 load third extended register.
- R3: With the strap low (DDR1), the accepted commands come in this order with these values: precharge-all, extended load 0x000, mode load 0x133, precharge-all, auto refresh, auto refresh, mode load 0x033. The value is 0 for every command that carries no register value.
- R4: With the strap high (DDR2), the order is: second-extended load, third-extended load, precharge-all, second-extended load, third-extended load, extended load 0x402, mode load 0x143, precharge-all, auto refresh, auto refresh, mode load 0x043, extended load 0x782, extended load 0x402.
- R5: Once a command is accepted, `cmd_valid` stays low for exactly `LONG_CYC` cycles and is then raised for the next command. The first two DDR2 commands use `SHORT_CYC` instead.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_code` and `cmd_value` hold their values into the next cycle.
- R7: The strap is sampled on the first rising clock edge after reset is released. Changing it later has no effect on the series until the next reset.
- R8: `refresh_word` is 0 until the wait after the last command has elapsed. From then on it reads 0x4138: bit 14 is the enable and bits 9:0 hold the interval, 312.
- R9: `init_done` rises one cycle after `refresh_word` becomes nonzero. It then stays high, and no further command is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| type_strap | input | 1 | Memory type select: 0 DDR1, 1 DDR2 |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The consumer accepts the offered command |
| cmd_code | output | 6 | One-hot command code |
| cmd_value | output | 13 | Register value that goes with the command |
| refresh_word | output | 16 | Refresh control word (enable and interval) |
| init_done | output | 1 | The series has completed |

## Verification
Both strap settings are run to completion. The code and value sequences tell the two series apart, including the second DLL-free mode load and the calibration enter/exit pair that only DDR2 has. `cmd_ready` follows a pseudo-random pattern, which shows that a stall holds the offer and never stretches or skips a wait. One run starts with a stall lasting several tens of cycles. In another run the strap flips partway through, and the count of accepted commands shows whether the flip changed the series. The length of each low gap tells the short waits apart from the long ones.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  parameter int CMD_W     = 6;
  parameter int MODE_W    = 13;
  parameter int REF_W     = 16;
  parameter int REF_EN    = 14;
  parameter int REF_IVL_W = 10;
  parameter int MAX_STEPS = 13;
  localparam int IDX_W    = $clog2(MAX_STEPS);

  localparam logic [CMD_W-1:0] C_MR   = 6'b000001;
  localparam logic [CMD_W-1:0] C_EMR  = 6'b000010;
  localparam logic [CMD_W-1:0] C_AREF = 6'b000100;
  localparam logic [CMD_W-1:0] C_PALL = 6'b001000;
  localparam logic [CMD_W-1:0] C_EMR2 = 6'b010000;
  localparam logic [CMD_W-1:0] C_EMR3 = 6'b100000;

  typedef struct packed {
    logic [CMD_W-1:0]  code;
    logic [MODE_W-1:0] value;
    logic              short_wait;
  } step_t;

  function automatic step_t mk(logic [CMD_W-1:0] c, int v, logic s);
    step_t r;
    r.code = c;
    r.value = MODE_W'(v);
    r.short_wait = s;
    return r;
  endfunction

  function automatic int seq_len(logic ddr2);
    return ddr2 ? 13 : 7;
  endfunction

  function automatic step_t ddr1_step(logic [IDX_W-1:0] i);
    case (i)
      4'd0: return mk(C_PALL, 0, 1'b0);
      4'd1: return mk(C_EMR, 'h000, 1'b0);
      4'd2: return mk(C_MR, 'h133, 1'b0);
      4'd3: return mk(C_PALL, 0, 1'b0);
      4'd4: return mk(C_AREF, 0, 1'b0);
      4'd5: return mk(C_AREF, 0, 1'b0);
      4'd6: return mk(C_MR, 'h033, 1'b0);
      default: return mk('0, 0, 1'b0);
    endcase
  endfunction

  function automatic step_t ddr2_step(logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return mk(C_EMR2, 0, 1'b1);
      4'd1:  return mk(C_EMR3, 0, 1'b1);
      4'd2:  return mk(C_PALL, 0, 1'b0);
      4'd3:  return mk(C_EMR2, 0, 1'b0);
      4'd4:  return mk(C_EMR3, 0, 1'b0);
      4'd5:  return mk(C_EMR, 'h402, 1'b0);
      4'd6:  return mk(C_MR, 'h143, 1'b0);
      4'd7:  return mk(C_PALL, 0, 1'b0);
      4'd8:  return mk(C_AREF, 0, 1'b0);
      4'd9:  return mk(C_AREF, 0, 1'b0);
      4'd10: return mk(C_MR, 'h043, 1'b0);
      4'd11: return mk(C_EMR, 'h782, 1'b0);
      4'd12: return mk(C_EMR, 'h402, 1'b0);
      default: return mk('0, 0, 1'b0);
    endcase
  endfunction

  function automatic logic [REF_W-1:0] refresh_ctrl(int interval);
    logic [REF_W-1:0] w;
    w = '0;
    w[REF_EN] = 1'b1;
    w[REF_IVL_W-1:0] = REF_IVL_W'(interval);
    return w;
  endfunction
endpackage

// File: rtl/dram_init_steps.sv
module dram_init_steps
  import dram_init_pkg::*;
(
  input  logic             ddr2,
  input  logic [IDX_W-1:0] idx,
  output step_t            step,
  output logic             last
);
  assign step = ddr2 ? ddr2_step(idx) : ddr1_step(idx);
  assign last = (int'(idx) == seq_len(ddr2) - 1);
endmodule

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int LONG_CYC  = 12500,
  parameter int SHORT_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic short_sel,
  output logic busy,
  output logic expire
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= short_sel ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  // R5: a new wait is only started once the previous one is over
  p_load_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int LONG_CYC     = 12500,
  parameter int SHORT_CYC    = 1250,
  parameter int REF_INTERVAL = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              type_strap,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [MODE_W-1:0] cmd_value,
  output logic [REF_W-1:0]  refresh_word,
  output logic              init_done
);
  typedef enum logic [1:0] {ST_BOOT, ST_ISSUE, ST_WAIT, ST_DONE} state_t;

  state_t           state_q;
  logic             ddr2_q;
  logic [IDX_W-1:0] idx_q;
  logic             ref_en_q;
  logic             done_q;
  step_t            cur_step;
  logic             cur_last;
  logic             handshake;
  logic             tmr_busy;
  logic             tmr_expire;

  dram_init_steps u_steps (
    .ddr2 (ddr2_q),
    .idx  (idx_q),
    .step (cur_step),
    .last (cur_last)
  );

  dram_init_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (handshake),
    .short_sel (cur_step.short_wait),
    .busy      (tmr_busy),
    .expire    (tmr_expire)
  );

  assign cmd_valid    = (state_q == ST_ISSUE);
  assign handshake    = cmd_valid && cmd_ready;
  assign cmd_code     = cmd_valid ? cur_step.code  : '0;
  assign cmd_value    = cmd_valid ? cur_step.value : '0;
  assign refresh_word = ref_en_q ? refresh_ctrl(REF_INTERVAL) : '0;
  assign init_done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_BOOT;
      ddr2_q   <= 1'b0;
      idx_q    <= '0;
      ref_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_BOOT: begin
          ddr2_q  <= type_strap;
          idx_q   <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (handshake) state_q <= ST_WAIT;
        ST_WAIT: if (tmr_expire) begin
          if (cur_last) begin
            ref_en_q <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        default: done_q <= 1'b1;
      endcase
    end
  end

  // R2: one command kind at a time
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(cmd_code) == 1));
  // R6: an offer is held until taken
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_value)));
  // R5: nothing is offered while a wait runs
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !cmd_valid);
  // R7: the memory type is frozen after the boot cycle
  p_strap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_BOOT) |=> $stable(ddr2_q));
  // R9: done is sticky and silences the command port
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && !cmd_valid));
  // R8: refresh is enabled before done rises
  p_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(refresh_word[REF_EN]));
endmodule

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;
  localparam int LONG  = 12;
  localparam int SHORT = 3;
  localparam int WD    = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        type_strap = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [5:0]  cmd_code;
  logic [12:0] cmd_value;
  logic [15:0] refresh_word;
  logic        init_done;

  always #4 clk = ~clk;

  dram_init_seq #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .REF_INTERVAL(312)) u0 (
    .clk(clk), .rst_n(rst_n), .type_strap(type_strap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_value(cmd_value), .refresh_word(refresh_word), .init_done(init_done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int e_code[16];
  int e_val[16];
  int e_short[16];
  int e_len;
  // model: 0 boot, 1 offering, 2 gap, 3 finished
  int m_mode = 0;
  int m_idx, m_gap, m_fc, hs_cnt, stall;
  bit m_ddr2;
  bit p_hold;
  logic [5:0]  p_code;
  logic [12:0] p_val;
  logic [7:0]  lfsr = 8'hA5;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic set_expect(input bit d2);
    for (int i = 0; i < 16; i++) begin e_code[i] = 0; e_val[i] = 0; e_short[i] = 0; end
    if (!d2) begin
      e_len = 7;
      e_code[0] = 8; e_code[1] = 2; e_val[1] = 0; e_code[2] = 1; e_val[2] = 'h133;
      e_code[3] = 8; e_code[4] = 4; e_code[5] = 4; e_code[6] = 1; e_val[6] = 'h33;
    end else begin
      e_len = 13;
      e_code[0] = 16; e_short[0] = 1; e_code[1] = 32; e_short[1] = 1;
      e_code[2] = 8; e_code[3] = 16; e_code[4] = 32;
      e_code[5] = 2; e_val[5] = 'h402; e_code[6] = 1; e_val[6] = 'h143;
      e_code[7] = 8; e_code[8] = 4; e_code[9] = 4;
      e_code[10] = 1; e_val[10] = 'h43; e_code[11] = 2; e_val[11] = 'h782;
      e_code[12] = 2; e_val[12] = 'h402;
    end
  endtask

  task automatic compare();
    if (!rst_n) begin
      chk({31'd0, cmd_valid}, 0, "R1 valid in reset");
      chk(int'(refresh_word), 0, "R1 refresh in reset");
      chk({31'd0, init_done}, 0, "R1 done in reset");
      return;
    end
    chk({31'd0, cmd_valid}, (m_mode == 1) ? 1 : 0, "R5 valid timing");
    if (m_mode == 1 && cmd_valid) begin
      chk($countones(cmd_code), 1, "R2 one-hot code");
      chk(int'(cmd_code), e_code[m_idx], m_ddr2 ? "R4 code" : "R3 code");
      chk(int'(cmd_value), e_val[m_idx], m_ddr2 ? "R4 value" : "R3 value");
    end
    chk(int'(refresh_word), (m_mode == 3) ? 'h4138 : 0, "R8 refresh word");
    chk({31'd0, init_done}, (m_mode == 3 && m_fc >= 1) ? 1 : 0, "R9 done flag");
    if (p_hold) begin
      chk({31'd0, cmd_valid}, 1, "R6 valid held");
      chk(int'(cmd_code), int'(p_code), "R6 code held");
      chk(int'(cmd_value), int'(p_val), "R6 value held");
    end
  endtask

  task automatic advance(input bit rdy);
    case (m_mode)
      0: begin m_ddr2 = type_strap; set_expect(m_ddr2); m_idx = 0; m_mode = 1; end
      1: if (rdy) begin hs_cnt++; m_gap = e_short[m_idx] ? SHORT : LONG; m_mode = 2; end
      2: begin
        m_gap--;
        if (m_gap == 0) begin
          if (m_idx == e_len - 1) begin m_mode = 3; m_fc = 0; end
          else begin m_idx++; m_mode = 1; end
        end
      end
      default: m_fc++;
    endcase
  endtask

  task automatic tick(input bit rst_next);
    bit rdy;
    @(negedge clk);
    cycles++;
    if (cycles > WD) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    compare();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stall > 0) begin rdy = 1'b0; stall--; end
    else rdy = lfsr[0] | lfsr[1];
    p_hold = rst_n && rst_next && cmd_valid && !rdy;
    p_code = cmd_code;
    p_val  = cmd_value;
    cmd_ready = rdy;
    rst_n = rst_next;
    if (!rst_n) begin m_mode = 0; p_hold = 1'b0; end
    else advance(rdy);
  endtask

  task automatic run_to_end(input int flip_at);
    for (int i = 0; i < 4000; i++) begin
      if (m_mode == 3 && m_fc > 5) break;
      if (i == flip_at) type_strap = ~type_strap;
      tick(1'b1);
    end
  endtask

  initial begin
    repeat (4) tick(1'b0);
    // DDR1, strap flipped partway through (R7)
    type_strap = 1'b0; hs_cnt = 0;
    tick(1'b1);
    run_to_end(20);
    chk(hs_cnt, 7, "R7 DDR1 series kept after strap flip");
    chk({31'd0, init_done}, 1, "R9 done after DDR1");
    // DDR2
    repeat (3) tick(1'b0);
    type_strap = 1'b1; hs_cnt = 0;
    tick(1'b1);
    run_to_end(-1);
    chk(hs_cnt, 13, "R4 DDR2 command count");
    chk(int'(refresh_word), 'h4138, "R8 final word");
    // DDR1 again with a long initial stall (R6)
    repeat (3) tick(1'b0);
    type_strap = 1'b0; hs_cnt = 0; stall = 40;
    tick(1'b1);
    run_to_end(-1);
    chk(hs_cnt, 7, "R3 DDR1 command count after stall");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule